// File: doc/BRIEF.md
# IQ Frame Modulation Classifier

This block runs a two-layer convolutional classifier over one frame of complex baseband samples and decides which of three modulation classes the frame belongs to. A frame holds 128 in-phase samples and 128 quadrature samples. Each sample is 18-bit signed fixed point with 12 fractional bits. A one-cycle `start` pulse copies the whole frame from the input ports into an internal register bank. The block then works through two stages.

The first stage is a convolution layer with three kernels. At each position, a kernel scales the I sample by one weight and the Q sample by another, adds the kernel bias, saturates the result and applies ReLU. The second stage is a dense layer that produces three class scores in parallel. It flattens the 774 stored activations with the kernel index innermost, the channel next and the position outermost, and accumulates in 32 bits. Once both stages finish, the block raises `done` for one cycle. The winning class index and the three raw scores stay on the outputs until the next frame completes.

All weights and biases are elaboration-time parameters. The dense weight table has a computed default in the package. A system integrator supplies trained values through parameter overrides.

Top module: `iqcnn_classifier`

## Requirements
- R1: After reset, `done` is 0, `class_o` is 0 and every field of `scores_o` is 0.
- R2: Convolution position p uses the zero-padded sequence. Position 0 sees a zero sample on both channels. Position p in 1..128 sees sample p-1. This gives 129 positions per kernel, and sample s sits at bits [18*s +: 18] of `frame_i` and `frame_q`.
- R3: Each convolution neuron is (w*x arithmetically shifted right by 12) + bias, using the kernel's I weight on the I sample and its Q weight on the Q sample. The sum is then clamped to the range -131072..131071.
- R4: A neuron whose clamped value has its sign bit set becomes 0 before it is stored, so every stored activation is non-negative.
- R5: The activation of kernel k, channel ch (0 = I, 1 = Q) at position p uses dense weight index p*6 + ch*3 + k. The weight for class c and index f sits at bits [18*(c*774+f) +: 18] of `DENSE_W`.
- R6: The score of class c is its 18-bit bias plus the sum over all 774 activations of (w*a arithmetically shifted right by 12), kept as a 32-bit signed value in `scores_o[32*c +: 32]`.
- R7: `done` rises exactly 517 rising edges after the edge that samples `start`. It stays high for exactly one cycle.
- R8: `class_o` is the index of the largest score. When scores are equal, the lowest index wins.
- R9: `class_o` and `scores_o` stay unchanged from one `done` until the next. A `start` seen while a frame is in progress is ignored.
- R10: The frame is captured on the `start` edge. Later changes on `frame_i` or `frame_q` do not affect the result of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame capture and launch pulse, honoured only when idle |
| frame_i | input | 2304 | 128 in-phase samples, 18 bits each |
| frame_q | input | 2304 | 128 quadrature samples, 18 bits each |
| done | output | 1 | One-cycle completion pulse |
| class_o | output | 2 | Index of the winning class |
| scores_o | output | 96 | Three 32-bit signed class scores |

## Verification
Every result of this block arrives together on a single edge, 517 rising edges after the edge that samples `start`. The driver records that start edge with each expected item. The monitor samples on falling edges, so when `done` appears it checks the edge distance as well as the class and the scores. The cycle after `done` is checked for the pulse falling. A few cycles later the held outputs are compared again. Restart attempts while a frame is in progress, and frame changes after `start`, are issued inside that 517-edge window so that their effect would land on the very result under check.

// File: rtl/iqcnn_pkg.sv
package iqcnn_pkg;

   localparam int DFLT_NSAMP = 128;
   localparam int DFLT_NKERN = 3;
   localparam int DFLT_NCLS  = 3;
   localparam int DFLT_DW    = 18;
   localparam int DFLT_NPOS  = DFLT_NSAMP + 1;
   localparam int DFLT_NFEAT = DFLT_NPOS * 2 * DFLT_NKERN;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_DENSE = 2'd2,
      ST_FIN   = 2'd3
   } iqcnn_state_e;

   // Default dense weight table: a deterministic spread of small values.
   function automatic logic [DFLT_NCLS*DFLT_NFEAT*DFLT_DW-1:0] dflt_dense_w();
      logic [DFLT_NCLS*DFLT_NFEAT*DFLT_DW-1:0] r;
      r = '0;
      for (int c = 0; c < DFLT_NCLS; c++) begin
         for (int f = 0; f < DFLT_NFEAT; f++) begin
            int v;
            v = ((f * 37 + c * 53 + 11) % 61) - 30;
            r[(c*DFLT_NFEAT+f)*DFLT_DW +: DFLT_DW] = DFLT_DW'(v * 96);
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/iqcnn_conv_kernel.sv
module iqcnn_conv_kernel #(
   parameter int DW   = 18,
   parameter int FRAC = 12,
   parameter logic signed [DW-1:0] W_I = '0,
   parameter logic signed [DW-1:0] W_Q = '0,
   parameter logic signed [DW-1:0] BIAS = '0
) (
   input  logic signed [DW-1:0] x_i,
   input  logic signed [DW-1:0] x_q,
   output logic signed [DW-1:0] n_i,
   output logic signed [DW-1:0] n_q
);
   localparam int SW = 2*DW + 1;
   localparam logic signed [SW-1:0] MAX_S = SW'((longint'(1) <<< (DW-1)) - 1);
   localparam logic signed [SW-1:0] MIN_S = -MAX_S - SW'(1);
   localparam logic signed [DW-1:0] MAX_D = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] MIN_D = {1'b1, {(DW-1){1'b0}}};

   function automatic logic signed [DW-1:0] neuron(input logic signed [DW-1:0] w,
                                                  input logic signed [DW-1:0] x);
      logic signed [2*DW-1:0] prod;
      logic signed [SW-1:0]   sum;
      logic signed [DW-1:0]   r;
      prod = w * x;
      sum  = SW'(prod >>> FRAC) + SW'(BIAS);
      if (sum > MAX_S)      r = MAX_D;
      else if (sum < MIN_S) r = MIN_D;
      else                  r = DW'(sum);
      if (r[DW-1]) r = '0;
      return r;
   endfunction

   always_comb begin
      n_i = neuron(W_I, x_i);
      n_q = neuron(W_Q, x_q);
   end
endmodule

// File: rtl/iqcnn_dense_acc.sv
module iqcnn_dense_acc #(
   parameter int DW    = 18,
   parameter int FRAC  = 12,
   parameter int ACC_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     en,
   input  logic signed [DW-1:0]     bias,
   input  logic signed [DW-1:0]     a_i,
   input  logic signed [DW-1:0]     a_q,
   input  logic signed [DW-1:0]     w_i,
   input  logic signed [DW-1:0]     w_q,
   output logic signed [ACC_W-1:0]  acc
);
   logic signed [2*DW-1:0]  prod_i, prod_q;
   logic signed [ACC_W-1:0] term_i, term_q;

   always_comb begin
      prod_i = w_i * a_i;
      prod_q = w_q * a_q;
      term_i = ACC_W'(prod_i >>> FRAC);
      term_q = ACC_W'(prod_q >>> FRAC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (clear) acc <= ACC_W'(bias);
      else if (en)    acc <= acc + term_i + term_q;
   end
endmodule

// File: rtl/iqcnn_argmax.sv
module iqcnn_argmax #(
   parameter int NCLS  = 3,
   parameter int ACC_W = 32,
   parameter int CW    = $clog2(NCLS)
) (
   input  logic [NCLS*ACC_W-1:0] scores,
   output logic [CW-1:0]         best
);
   logic signed [ACC_W-1:0] top;
   always_comb begin
      best = '0;
      top  = scores[ACC_W-1:0];
      for (int c = 1; c < NCLS; c++) begin
         if ($signed(scores[c*ACC_W +: ACC_W]) > top) begin
            top  = scores[c*ACC_W +: ACC_W];
            best = CW'(c);
         end
      end
   end
endmodule

// File: rtl/iqcnn_classifier.sv
module iqcnn_classifier #(
   parameter int NSAMP = 128,
   parameter int NKERN = 3,
   parameter int NCLS  = 3,
   parameter int DW    = 18,
   parameter int FRAC  = 12,
   parameter int ACC_W = 32,
   parameter logic [NKERN*2*DW-1:0] CONV_W = {18'(1024), 18'(98304),
                                              18'(4096), 18'(-5120),
                                              18'(-2048), 18'(3072)},
   parameter logic [NKERN*DW-1:0]   CONV_B = {18'(2048), 18'(-256), 18'(512)},
   parameter logic [NCLS*(NSAMP+1)*2*NKERN*DW-1:0] DENSE_W = iqcnn_pkg::dflt_dense_w(),
   parameter logic [NCLS*DW-1:0]    DENSE_B = {18'(300), 18'(-200), 18'(100)}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [NSAMP*DW-1:0]    frame_i,
   input  logic [NSAMP*DW-1:0]    frame_q,
   output logic                   done,
   output logic [$clog2(NCLS)-1:0] class_o,
   output logic [NCLS*ACC_W-1:0]  scores_o
);
   import iqcnn_pkg::*;

   localparam int NPOS  = NSAMP + 1;
   localparam int NFEAT = NPOS * 2 * NKERN;
   localparam int PW    = $clog2(NPOS);
   localparam int KW    = (NKERN > 1) ? $clog2(NKERN) : 1;
   localparam int CW    = $clog2(NCLS);

   if (NSAMP < 1 || NKERN < 1 || NCLS < 2) begin : g_bad_count
      $error("iqcnn_classifier: sample, kernel or class count out of range");
   end
   if (FRAC >= DW) begin : g_bad_frac
      $error("iqcnn_classifier: fraction bits must be below data width");
   end
   if (ACC_W < 2*DW - FRAC + 1) begin : g_bad_acc
      $error("iqcnn_classifier: accumulator too narrow for one product");
   end

   iqcnn_state_e state;
   logic [PW-1:0] pos_q;
   logic [KW-1:0] k_q;

   logic signed [DW-1:0] smp_i [NSAMP];
   logic signed [DW-1:0] smp_q [NSAMP];
   logic signed [DW-1:0] fstore [NPOS][2][NKERN];

   logic signed [DW-1:0] cx_i, cx_q;
   logic signed [DW-1:0] cn_i [NKERN];
   logic signed [DW-1:0] cn_q [NKERN];

   wire conv_last  = (state == ST_CONV)  && (pos_q == PW'(NPOS-1));
   wire dense_last = (state == ST_DENSE) && (pos_q == PW'(NPOS-1)) && (k_q == KW'(NKERN-1));

   // Zero-padded input: position 0 is the pad, position p reads sample p-1.
   always_comb begin
      if (pos_q == '0) begin
         cx_i = '0;
         cx_q = '0;
      end else begin
         cx_i = smp_i[int'(pos_q) - 1];
         cx_q = smp_q[int'(pos_q) - 1];
      end
   end

   for (genvar k = 0; k < NKERN; k++) begin : g_kern
      iqcnn_conv_kernel #(
         .DW(DW), .FRAC(FRAC),
         .W_I(CONV_W[(2*k)*DW +: DW]),
         .W_Q(CONV_W[(2*k+1)*DW +: DW]),
         .BIAS(CONV_B[k*DW +: DW])
      ) u_kern (
         .x_i(cx_i), .x_q(cx_q), .n_i(cn_i[k]), .n_q(cn_q[k])
      );
   end

   // Sequencer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pos_q <= '0;
         k_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_CONV;
               pos_q <= '0;
               k_q   <= '0;
            end
            ST_CONV: begin
               if (conv_last) begin
                  state <= ST_DENSE;
                  pos_q <= '0;
               end else pos_q <= pos_q + PW'(1);
            end
            ST_DENSE: begin
               if (dense_last) state <= ST_FIN;
               else if (k_q == KW'(NKERN-1)) begin
                  k_q   <= '0;
                  pos_q <= pos_q + PW'(1);
               end else k_q <= k_q + KW'(1);
            end
            ST_FIN: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Frame capture and activation store (data path, no reset needed).
   always_ff @(posedge clk) begin
      if (state == ST_IDLE && start) begin
         for (int s = 0; s < NSAMP; s++) begin
            smp_i[s] <= frame_i[s*DW +: DW];
            smp_q[s] <= frame_q[s*DW +: DW];
         end
      end
      if (state == ST_CONV) begin
         for (int k = 0; k < NKERN; k++) begin
            fstore[pos_q][0][k] <= cn_i[k];
            fstore[pos_q][1][k] <= cn_q[k];
         end
      end
   end

   // Dense layer: one (position, kernel) pair per cycle, all classes at once.
   logic signed [DW-1:0] a_i, a_q;
   int fidx_i, fidx_q;
   logic [NCLS*ACC_W-1:0] acc_all;

   always_comb begin
      a_i    = fstore[pos_q][0][k_q];
      a_q    = fstore[pos_q][1][k_q];
      fidx_i = int'(pos_q) * 2 * NKERN + int'(k_q);
      fidx_q = fidx_i + NKERN;
   end

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      logic signed [DW-1:0]    w_i, w_q;
      logic signed [ACC_W-1:0] acc;
      always_comb begin
         w_i = DENSE_W[(c*NFEAT + fidx_i)*DW +: DW];
         w_q = DENSE_W[(c*NFEAT + fidx_q)*DW +: DW];
      end
      iqcnn_dense_acc #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W)) u_acc (
         .clk(clk), .rst_n(rst_n),
         .clear(conv_last), .en(state == ST_DENSE),
         .bias(DENSE_B[c*DW +: DW]),
         .a_i(a_i), .a_q(a_q), .w_i(w_i), .w_q(w_q),
         .acc(acc)
      );
      assign acc_all[c*ACC_W +: ACC_W] = acc;
   end

   logic [CW-1:0] best;
   iqcnn_argmax #(.NCLS(NCLS), .ACC_W(ACC_W), .CW(CW)) u_argmax (
      .scores(acc_all), .best(best)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         class_o  <= '0;
         scores_o <= '0;
      end else begin
         done <= (state == ST_FIN);
         if (state == ST_FIN) begin
            class_o  <= best;
            scores_o <= acc_all;
         end
      end
   end

   // ---------------- assertions ----------------
   p_feat_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DENSE) |-> (!a_i[DW-1] && !a_q[DW-1]));

   p_conv_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_last |=> (state == ST_DENSE && pos_q == '0 && k_q == '0));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV && start && !conv_last) |=> (state == ST_CONV && pos_q != '0));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_FIN) |=> ($stable(class_o) && $stable(scores_o)));

   for (genvar c = 0; c < NCLS; c++) begin : g_chk
      p_argmax_r8: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> ((int'(class_o) <= c) ?
                   ($signed(scores_o[c*ACC_W +: ACC_W]) <= $signed(scores_o[class_o*ACC_W +: ACC_W])) :
                   ($signed(scores_o[c*ACC_W +: ACC_W]) <  $signed(scores_o[class_o*ACC_W +: ACC_W]))) ||
                  (int'(class_o) == c));
   end
endmodule

// File: tb/sim_iqcnn_classifier.sv
module sim_iqcnn_classifier;
   localparam int NS = 128, NK = 3, NC = 3, DW = 18, NP = NS + 1, NF = NP * 2 * NK;
   localparam int LAT = 517;
   localparam logic [NK*2*DW-1:0] CW_P = {18'(1024), 18'(98304), 18'(4096),
                                         18'(-5120), 18'(-2048), 18'(3072)};
   localparam logic [NK*DW-1:0] CB_P = {18'(2048), 18'(-256), 18'(512)};
   localparam logic [NC*NF*DW-1:0] DW_P = iqcnn_pkg::dflt_dense_w();
   localparam logic [NC*DW-1:0] DB_P = {18'(300), 18'(-200), 18'(100)};
   localparam logic [NC*DW-1:0] DB_TIE = {18'(700), 18'(700), 18'(-5)};

   logic clk = 0, rst_n = 0, start = 0;
   logic [NS*DW-1:0] frame_i = '0, frame_q = '0;
   logic done, done1;
   logic [1:0] class_o, class1;
   logic [NC*32-1:0] scores_o, scores1;

   always #10 clk = ~clk;

   iqcnn_classifier #(.CONV_W(CW_P), .CONV_B(CB_P), .DENSE_W(DW_P), .DENSE_B(DB_P)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .frame_i(frame_i), .frame_q(frame_q),
      .done(done), .class_o(class_o), .scores_o(scores_o));

   iqcnn_classifier #(.CONV_W(CW_P), .CONV_B(CB_P), .DENSE_W('0), .DENSE_B(DB_TIE)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start), .frame_i(frame_i), .frame_q(frame_q),
      .done(done1), .class_o(class1), .scores_o(scores1));

   int checks = 0, fails = 0, cyc = 0, seen = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { int cls; int s0; int s1; int s2; int scyc; } exp_t;
   exp_t q[$];
   exp_t last;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // ---- reference model from the requirements ----
   function automatic longint neuron(longint w, longint x, longint b);
      longint v;
      v = ((w * x) >>> 12) + b;                 // R3
      if (v > 131071) v = 131071;
      if (v < -131072) v = -131072;
      if (v < 0) v = 0;                         // R4
      return v;
   endfunction

   function automatic longint sx(logic [DW-1:0] v);
      return longint'($signed(v));
   endfunction

   function automatic exp_t model(logic [NS*DW-1:0] fi, logic [NS*DW-1:0] fq);
      exp_t e;
      longint acc [NC];
      for (int c = 0; c < NC; c++) acc[c] = sx(DB_P[c*DW +: DW]);
      for (int p = 0; p < NP; p++) begin
         longint xi, xq;
         xi = (p == 0) ? 0 : sx(fi[(p-1)*DW +: DW]);   // R2 padding
         xq = (p == 0) ? 0 : sx(fq[(p-1)*DW +: DW]);
         for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < NK; k++) begin
               longint a;
               a = neuron(sx(CW_P[(2*k+ch)*DW +: DW]), ch == 0 ? xi : xq, sx(CB_P[k*DW +: DW]));
               for (int c = 0; c < NC; c++)
                  acc[c] += (sx(DW_P[(c*NF + p*6 + ch*3 + k)*DW +: DW]) * a) >>> 12;  // R5 R6
            end
         end
      end
      e.s0 = int'(acc[0]); e.s1 = int'(acc[1]); e.s2 = int'(acc[2]);
      e.cls = 0;
      if (e.s1 > e.s0) e.cls = 1;
      if (e.s2 > ((e.cls == 1) ? e.s1 : e.s0)) e.cls = 2;
      e.scyc = 0;
      return e;
   endfunction

   // ---- driver ----
   // mode 0: plain; 1: restart attempt while busy; 2: frame change after start
   task automatic run_frame(input logic [NS*DW-1:0] fi, input logic [NS*DW-1:0] fq, input int mode);
      exp_t e;
      int want;
      e = model(fi, fq);
      @(negedge clk);
      frame_i = fi; frame_q = fq; start = 1;
      e.scyc = cyc + 1;
      q.push_back(e);
      want = seen + 1;
      @(negedge clk);
      start = 0;
      if (mode == 2) begin
         frame_i = ~fi; frame_q = {NS{18'(-70000)}};   // R10
      end
      if (mode == 1) begin
         repeat (40) @(negedge clk);
         frame_i = {NS{18'(131071)}}; frame_q = ~fq;
         start = 1;                                      // R9 ignored
         @(negedge clk);
         start = 0;
      end
      wait (seen == want);
      repeat (5) @(negedge clk);
      chk(done == 0, "R7 done low after pulse", done, 0);
      chk(class_o == 2'(last.cls), "R9 class held", class_o, last.cls);
      chk($signed(scores_o[63:32]) == last.s1, "R9 score held", $signed(scores_o[63:32]), last.s1);
   endtask

   // ---- monitor ----
   bit prev_done = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done) chk(done == 0, "R7 one-cycle pulse", done, 0);
         if (done) begin
            exp_t e;
            if (q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
            else begin
               e = q.pop_front();
               chk(cyc - e.scyc == LAT, "R7 latency", cyc - e.scyc, LAT);
               chk(int'(class_o) == e.cls, "R8 class", class_o, e.cls);
               chk($signed(scores_o[31:0]) == e.s0, "R6 score0", $signed(scores_o[31:0]), e.s0);
               chk($signed(scores_o[63:32]) == e.s1, "R6 score1", $signed(scores_o[63:32]), e.s1);
               chk($signed(scores_o[95:64]) == e.s2, "R6 score2", $signed(scores_o[95:64]), e.s2);
               last = e;
            end
            seen++;
         end
         if (done1) begin
            chk(class1 == 2'd1, "R8 tie lower index", class1, 1);
            chk($signed(scores1[95:64]) == 700, "R6 bias-only score", $signed(scores1[95:64]), 700);
         end
         prev_done = done;
      end
   end

   function automatic logic [NS*DW-1:0] pat(int kind, int ch);
      logic [NS*DW-1:0] r;
      for (int s = 0; s < NS; s++) begin
         int v;
         case (kind)
            0: v = 0;
            1: v = (s == 0 && ch == 0) ? 4096 : 0;
            2: v = ch ? (9000 - s * 150) : (s * 300 - 19000);
            3: v = ch ? -131072 : 131071;
            4: v = ((s * 7919 + ch * 131) % 40000) - 20000;
            default: v = ch ? ((s % 3) * 12000 - 6000) : ((s % 5) * 9000 - 30000);
         endcase
         r[s*DW +: DW] = DW'(v);
      end
      return r;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk(done == 0, "R1 done reset", done, 0);
      chk(class_o == 0, "R1 class reset", class_o, 0);
      chk(scores_o == '0, "R1 scores reset", scores_o[31:0], 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      run_frame(pat(0, 0), pat(0, 1), 0);   // R2 pad only / biases
      run_frame(pat(1, 0), pat(1, 1), 0);   // R2 impulse at sample 0 lands at position 1
      run_frame(pat(2, 0), pat(2, 1), 0);   // R4 ramp with negative neurons
      run_frame(pat(3, 0), pat(3, 1), 0);   // R3 saturation
      run_frame(pat(4, 0), pat(4, 1), 1);   // R9 restart ignored
      run_frame(pat(5, 0), pat(5, 1), 2);   // R10 capture
      run_frame(pat(2, 1), pat(4, 0), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait (cyc > 60000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 60000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule